// File: doc/BRIEF.md
# Privilege Violation Exception Sequencer

This block sits beside the instruction decoder. It takes the processor into a privilege-violation exception whenever a privileged instruction is decoded in user mode. The trigger is recognised in the decode cycle, before the instruction runs. In that same cycle the block raises a combinational inhibit, so the instruction never takes effect. The block then takes an internal snapshot of the status register, the program counter of the faulting instruction, the supervisor stack pointer and the vector base.

One cycle after detection the block writes back a live status register with the supervisor bit set and both trace bits cleared. It then pushes a four-word exception frame through a word-write port with a request/acknowledge handshake. The supervisor stack pointer is pre-decremented by one word before each write, and the frame is built from the highest address down. Next it reads the handler address for vector 8 from the vector table and hands that address to instruction fetch. The stack pointer is loaded with its final value in the same cycle. Fetch then performs the prefetches that refill the pipeline.

The state machine has eight named states. `ST_IDLE` waits for a trigger. `ST_ENTER` writes the supervisor status. `ST_PUSH_OFS`, `ST_PUSH_PCL`, `ST_PUSH_PCH` and `ST_PUSH_SR` each write one frame word. `ST_VEC_FETCH` reads the vector. `ST_REDIRECT` loads the new PC. The transitions are:
- IDLE→ENTER on a trigger.
- ENTER→PUSH_OFS unconditionally.
- Each push state advances on its write acknowledge: PUSH_OFS→PUSH_PCL→PUSH_PCH→PUSH_SR→VEC_FETCH.
- VEC_FETCH→REDIRECT on the read acknowledge.
- REDIRECT→IDLE unconditionally.

Top module: `priv_exc_seq`

## Requirements
- R1: A trigger is `dec_valid=1`, `dec_priv=1` and status bit 13 (supervisor) of `sr_in` at 0, while `busy=0`. `exec_inhibit` is 1 in the trigger cycle itself, and `busy` is 1 from the next cycle.
- R2: A decode with `dec_priv=0`, or with status bit 13 at 1, starts nothing. `exec_inhibit`, `busy`, `mem_wr_req` and `vec_rd_req` all stay 0.
- R3: One cycle after the trigger, `sr_we` pulses for one cycle. `sr_out` equals the captured `sr_in` with bit 13 set and trace bits 15 and 14 cleared.
- R4: Exactly four stack writes follow, at byte addresses SP−2, SP−4, SP−6 and SP−8 in that order. SP is the `sp_in` value captured at the trigger, and the arithmetic wraps modulo 2^32.
- R5: The frame words are, in write order:
  - 0x0020, which is format 0 in bits 15:12 and the vector offset 8×4 in bits 11:0;
  - the captured PC bits 15:0;
  - the captured PC bits 31:16;
  - the captured, unmodified status register.
- R6: A write request holds its address and data steady until `mem_wr_ack`. The transfer completes on the edge where request and acknowledge are both 1.
- R7: After the fourth write, the block reads the vector table at `vbr_in`+0x20, holding the request until `vec_rd_ack`. It never requests a read and a write together.
- R8: In the cycle after the read acknowledge, `pc_load` and `sp_we` pulse together for one cycle. `pc_new` carries the word read from the table, and `sp_out` carries SP−8.
- R9: While `busy=1`, decode requests are ignored. Each exception produces exactly one `pc_load` and four writes, and it stacks the PC captured at the trigger. `busy` falls after the `pc_load` cycle.
- R10: After reset the block is idle, and all request, strobe and inhibit outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoder presents an instruction this cycle |
| dec_priv | input | 1 | Decoded instruction is privileged |
| cur_pc | input | 32 | Address of the decoded instruction's first word |
| sr_in | input | 16 | Live status register |
| sp_in | input | 32 | Supervisor stack pointer |
| vbr_in | input | 32 | Vector table base address |
| exec_inhibit | output | 1 | Suppress execution of the decoded instruction |
| busy | output | 1 | Exception sequence in progress |
| sr_we | output | 1 | Write strobe for the live status register |
| sr_out | output | 16 | New status register value |
| mem_wr_req | output | 1 | Stack word write request |
| mem_wr_addr | output | 32 | Stack write byte address |
| mem_wr_data | output | 16 | Stack write data word |
| mem_wr_ack | input | 1 | Stack write accepted |
| vec_rd_req | output | 1 | Vector table read request |
| vec_rd_addr | output | 32 | Vector table read address |
| vec_rd_ack | input | 1 | Vector read data valid |
| vec_rd_data | input | 32 | Handler address read from the table |
| pc_load | output | 1 | Redirect instruction fetch |
| pc_new | output | 32 | Handler address for fetch |
| sp_we | output | 1 | Write strobe for the stack pointer |
| sp_out | output | 32 | Final supervisor stack pointer |

## Verification
- `exec_inhibit` is combinational, so the bench reads it in the trigger cycle, a short delay after driving the decode inputs on the falling edge.
- `sr_we` is due one register later, so it is sampled at the next falling edge. `busy` is checked on every falling edge from there up to the `pc_load` cycle.
- Writes and the vector read are logged on the falling edge where the bench raises an acknowledge. The transfer then completes on the following rising edge.
- `pc_load` and `sp_we` are due one cycle after the read transfer. The bench compares every logged value only after `pc_load` has been seen, against frames it computes itself from the captured stimulus.

// File: rtl/priv_exc_pkg.sv
package priv_exc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTER,
        ST_PUSH_OFS,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_SR,
        ST_VEC_FETCH,
        ST_REDIRECT
    } seq_state_t;

    // Status register bit positions that other logic decodes
    localparam int SR_SUP_BIT = 13;
    localparam int SR_TR0_BIT = 14;
    localparam int SR_TR1_BIT = 15;

    // Stack frame format code placed in the top nibble of the offset word
    localparam logic [3:0] FRAME_FMT = 4'h0;

endpackage

// File: rtl/pes_sr_shaper.sv
module pes_sr_shaper #(
    parameter int SR_W = 16
) (
    input  logic [SR_W-1:0] sr_snap,
    output logic [SR_W-1:0] sr_sup
);
    import priv_exc_pkg::*;

    always_comb begin
        sr_sup             = sr_snap;
        sr_sup[SR_SUP_BIT] = 1'b1;
        sr_sup[SR_TR1_BIT] = 1'b0;
        sr_sup[SR_TR0_BIT] = 1'b0;
    end

endmodule

// File: rtl/pes_context.sv
module pes_context #(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              wr_fire,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] vbr_in,
    input  logic [ADDR_W-1:0] rd_data,
    output logic [ADDR_W-1:0] pc_snap,
    output logic [SR_W-1:0]   sr_snap,
    output logic [ADDR_W-1:0] sp_work,
    output logic [ADDR_W-1:0] vbr_snap,
    output logic [ADDR_W-1:0] pc_vec
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_snap  <= '0;
            sr_snap  <= '0;
            sp_work  <= '0;
            vbr_snap <= '0;
            pc_vec   <= '0;
        end else begin
            if (capture) begin
                pc_snap  <= cur_pc;
                sr_snap  <= sr_in;
                sp_work  <= sp_in;
                vbr_snap <= vbr_in;
            end else if (wr_fire) begin
                sp_work <= sp_work - WORD_BYTES;
            end
            if (rd_fire) begin
                pc_vec <= rd_data;
            end
        end
    end

endmodule

// File: rtl/pes_frame_builder.sv
module pes_frame_builder #(
    parameter int ADDR_W  = 32,
    parameter int SR_W    = 16,
    parameter int WORD_W  = 16,
    parameter int VEC_NUM = 8
) (
    input  priv_exc_pkg::seq_state_t state,
    input  logic [ADDR_W-1:0]        pc_snap,
    input  logic [SR_W-1:0]          sr_snap,
    input  logic [ADDR_W-1:0]        sp_work,
    input  logic [ADDR_W-1:0]        vbr_snap,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [WORD_W-1:0]        wr_data,
    output logic [ADDR_W-1:0]        vec_addr
);
    import priv_exc_pkg::*;

    localparam int                OFS_W      = WORD_W - 4;
    localparam int                VEC_OFS    = VEC_NUM * 4;
    localparam logic [WORD_W-1:0] OFS_WORD   = {FRAME_FMT, OFS_W'(VEC_OFS)};
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

    logic [WORD_W-1:0] pc_lo;
    logic [WORD_W-1:0] pc_hi;

    assign pc_lo    = pc_snap[WORD_W-1:0];
    assign pc_hi    = WORD_W'(pc_snap >> WORD_W);
    assign wr_addr  = sp_work - WORD_BYTES;
    assign vec_addr = vbr_snap + ADDR_W'(VEC_OFS);

    always_comb begin
        unique case (state)
            ST_PUSH_OFS: wr_data = OFS_WORD;
            ST_PUSH_PCL: wr_data = pc_lo;
            ST_PUSH_PCH: wr_data = pc_hi;
            ST_PUSH_SR:  wr_data = WORD_W'(sr_snap);
            default:     wr_data = '0;
        endcase
    end

endmodule

// File: rtl/pes_fsm.sv
module pes_fsm (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trigger,
    input  logic                      wr_ack,
    input  logic                      rd_ack,
    output priv_exc_pkg::seq_state_t  state,
    output logic                      busy,
    output logic                      sr_we,
    output logic                      wr_req,
    output logic                      rd_req,
    output logic                      pc_load,
    output logic                      sp_we
);
    import priv_exc_pkg::*;

    seq_state_t state_q;
    seq_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (trigger) state_d = ST_ENTER;
            ST_ENTER:     state_d = ST_PUSH_OFS;
            ST_PUSH_OFS:  if (wr_ack) state_d = ST_PUSH_PCL;
            ST_PUSH_PCL:  if (wr_ack) state_d = ST_PUSH_PCH;
            ST_PUSH_PCH:  if (wr_ack) state_d = ST_PUSH_SR;
            ST_PUSH_SR:   if (wr_ack) state_d = ST_VEC_FETCH;
            ST_VEC_FETCH: if (rd_ack) state_d = ST_REDIRECT;
            ST_REDIRECT:  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = 1'b1;
        sr_we   = 1'b0;
        wr_req  = 1'b0;
        rd_req  = 1'b0;
        pc_load = 1'b0;
        sp_we   = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_ENTER:     sr_we = 1'b1;
            ST_PUSH_OFS,
            ST_PUSH_PCL,
            ST_PUSH_PCH,
            ST_PUSH_SR:   wr_req = 1'b1;
            ST_VEC_FETCH: rd_req = 1'b1;
            ST_REDIRECT: begin
                pc_load = 1'b1;
                sp_we   = 1'b1;
            end
            default:      busy = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/priv_exc_seq.sv
module priv_exc_seq #(
    parameter int ADDR_W  = 32,
    parameter int SR_W    = 16,
    parameter int WORD_W  = 16,
    parameter int VEC_NUM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic              dec_priv,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] vbr_in,
    output logic              exec_inhibit,
    output logic              busy,
    output logic              sr_we,
    output logic [SR_W-1:0]   sr_out,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              vec_rd_req,
    output logic [ADDR_W-1:0] vec_rd_addr,
    input  logic              vec_rd_ack,
    input  logic [ADDR_W-1:0] vec_rd_data,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_new,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_out
);
    import priv_exc_pkg::*;

    seq_state_t        state;
    logic              trigger;
    logic              wr_fire;
    logic              rd_fire;
    logic [ADDR_W-1:0] pc_snap;
    logic [SR_W-1:0]   sr_snap;
    logic [ADDR_W-1:0] sp_work;
    logic [ADDR_W-1:0] vbr_snap;
    logic [ADDR_W-1:0] pc_vec;

    assign trigger      = dec_valid && dec_priv && !sr_in[SR_SUP_BIT] && !busy;
    assign exec_inhibit = trigger || busy;
    assign wr_fire      = mem_wr_req && mem_wr_ack;
    assign rd_fire      = vec_rd_req && vec_rd_ack;

    pes_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .wr_ack  (mem_wr_ack),
        .rd_ack  (vec_rd_ack),
        .state   (state),
        .busy    (busy),
        .sr_we   (sr_we),
        .wr_req  (mem_wr_req),
        .rd_req  (vec_rd_req),
        .pc_load (pc_load),
        .sp_we   (sp_we)
    );

    pes_context #(.ADDR_W(ADDR_W), .SR_W(SR_W), .WORD_W(WORD_W)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (trigger),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .cur_pc   (cur_pc),
        .sr_in    (sr_in),
        .sp_in    (sp_in),
        .vbr_in   (vbr_in),
        .rd_data  (vec_rd_data),
        .pc_snap  (pc_snap),
        .sr_snap  (sr_snap),
        .sp_work  (sp_work),
        .vbr_snap (vbr_snap),
        .pc_vec   (pc_vec)
    );

    pes_frame_builder #(
        .ADDR_W(ADDR_W), .SR_W(SR_W), .WORD_W(WORD_W), .VEC_NUM(VEC_NUM)
    ) u_frame (
        .state    (state),
        .pc_snap  (pc_snap),
        .sr_snap  (sr_snap),
        .sp_work  (sp_work),
        .vbr_snap (vbr_snap),
        .wr_addr  (mem_wr_addr),
        .wr_data  (mem_wr_data),
        .vec_addr (vec_rd_addr)
    );

    pes_sr_shaper #(.SR_W(SR_W)) u_shape (
        .sr_snap (sr_snap),
        .sr_sup  (sr_out)
    );

    assign pc_new = pc_vec;
    assign sp_out = sp_work;

endmodule

// File: rtl/priv_exc_seq_checker.sv
module priv_exc_seq_checker #(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic              dec_priv,
    input logic [SR_W-1:0]   sr_in,
    input logic              exec_inhibit,
    input logic              busy,
    input logic              sr_we,
    input logic [SR_W-1:0]   sr_out,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [WORD_W-1:0] mem_wr_data,
    input logic              mem_wr_ack,
    input logic              vec_rd_req,
    input logic [ADDR_W-1:0] vec_rd_addr,
    input logic              vec_rd_ack,
    input logic              pc_load,
    input logic              sp_we
);
    AST_TRIGGER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dec_valid && dec_priv && !sr_in[13]) |=> busy); // R1
    AST_SUP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(dec_valid && dec_priv && !sr_in[13])) |=> !busy); // R2
    AST_SR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> (sr_out[13] && !sr_out[15] && !sr_out[14])); // R3
    AST_SR_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && exec_inhibit) |=> sr_we); // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=>
            (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_req && !vec_rd_ack) |=> (vec_rd_req && $stable(vec_rd_addr))); // R7
    AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_req && vec_rd_req)); // R7
    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R8
    AST_REDIRECT_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_req && vec_rd_ack) |=> (pc_load && sp_we)); // R8
    AST_INHIBIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> exec_inhibit); // R9
    AST_IDLE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy); // R9
endmodule

bind priv_exc_seq priv_exc_seq_checker #(
    .ADDR_W(ADDR_W), .SR_W(SR_W), .WORD_W(WORD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_valid    (dec_valid),
    .dec_priv     (dec_priv),
    .sr_in        (sr_in),
    .exec_inhibit (exec_inhibit),
    .busy         (busy),
    .sr_we        (sr_we),
    .sr_out       (sr_out),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack),
    .vec_rd_req   (vec_rd_req),
    .vec_rd_addr  (vec_rd_addr),
    .vec_rd_ack   (vec_rd_ack),
    .pc_load      (pc_load),
    .sp_we        (sp_we)
);

// File: tb/tb_priv_exc_seq.sv
`timescale 1ns/1ps
module tb_priv_exc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic        dec_priv = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] sp_in = '0;
    logic [31:0] vbr_in = '0;
    logic        exec_inhibit, busy, sr_we, mem_wr_req, vec_rd_req, pc_load, sp_we;
    logic [15:0] sr_out, mem_wr_data;
    logic [31:0] mem_wr_addr, vec_rd_addr, pc_new, sp_out;
    logic        mem_wr_ack = 1'b0;
    logic        vec_rd_ack = 1'b0;
    logic [31:0] vec_rd_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Event logs filled by the responder (running counts, never reset)
    logic [31:0] wa_log [64];
    logic [15:0] wd_log [64];
    int          wr_cnt = 0;
    logic [15:0] sr_log;
    int          sr_cnt = 0;
    logic [31:0] ra_log;
    int          rd_cnt = 0;
    logic [31:0] pcn_log, spo_log;
    int          pc_cnt = 0;
    int          spwe_cnt = 0;
    int          wr_wait = 0;
    int          rd_wait = 0;

    always #5 clk = ~clk;

    priv_exc_seq dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_priv(dec_priv),
        .cur_pc(cur_pc), .sr_in(sr_in), .sp_in(sp_in), .vbr_in(vbr_in),
        .exec_inhibit(exec_inhibit), .busy(busy), .sr_we(sr_we), .sr_out(sr_out),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack), .vec_rd_req(vec_rd_req), .vec_rd_addr(vec_rd_addr),
        .vec_rd_ack(vec_rd_ack), .vec_rd_data(vec_rd_data), .pc_load(pc_load),
        .pc_new(pc_new), .sp_we(sp_we), .sp_out(sp_out)
    );

    function automatic logic [31:0] vec_mem(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] ^ a[15:0]} & 32'hFFFF_FFFE;
    endfunction

    function automatic logic [15:0] sup_sr(input logic [15:0] s);
        return (s | 16'h2000) & 16'h3FFF;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Memory responder and output monitor, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (sr_we)   begin sr_log = sr_out; sr_cnt++; end
        if (pc_load) begin pcn_log = pc_new; spo_log = sp_out; pc_cnt++; end
        if (sp_we)   spwe_cnt++;
        if (mem_wr_ack) begin
            mem_wr_ack = 1'b0;
        end else if (mem_wr_req) begin
            if (wr_wait == 0) begin
                wr_wait = 1 + int'($urandom_range(0, 3));
            end
            wr_wait--;
            if (wr_wait == 0) begin
                wa_log[wr_cnt % 64] = mem_wr_addr;
                wd_log[wr_cnt % 64] = mem_wr_data;
                wr_cnt++;
                mem_wr_ack = 1'b1;
            end
        end
        if (vec_rd_ack) begin
            vec_rd_ack = 1'b0;
        end else if (vec_rd_req) begin
            if (rd_wait == 0) begin
                rd_wait = 1 + int'($urandom_range(0, 3));
            end
            rd_wait--;
            if (rd_wait == 0) begin
                ra_log = vec_rd_addr;
                rd_cnt++;
                vec_rd_data = vec_mem(vec_rd_addr);
                vec_rd_ack = 1'b1;
            end
        end
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    // One exception; poke keeps a different decode request active while busy
    task automatic run_exc(input logic [31:0] pc, input logic [15:0] sr,
                           input logic [31:0] sp, input logic [31:0] vbr, input bit poke);
        int wb = wr_cnt;
        int pb = pc_cnt;
        int sb = sr_cnt;
        int spb = spwe_cnt;
        bit busy_ok = 1'b1;
        logic [31:0] busy_bad = '0;
        logic [15:0] exp_w [4];
        @(negedge clk);
        dec_valid = 1'b1; dec_priv = 1'b1;
        cur_pc = pc; sr_in = sr; sp_in = sp; vbr_in = vbr;
        #1;
        check(exec_inhibit === 1'b1 && busy === 1'b0, "R1 inhibit at trigger",
              {30'd0, exec_inhibit, busy}, 32'h2);
        @(negedge clk); #1;
        check(busy === 1'b1, "R1 busy after trigger", {31'd0, busy}, 32'h1);
        check(sr_cnt == sb + 1 && sr_log == sup_sr(sr), "R3 supervisor sr",
              {16'd0, sr_log}, {16'd0, sup_sr(sr)});
        if (poke) begin
            cur_pc = pc ^ 32'h0000_4440; sr_in = 16'h0000;
            sp_in = sp ^ 32'h100; vbr_in = vbr ^ 32'h200;
        end else begin
            dec_valid = 1'b0;
        end
        for (int i = 0; i < 200 && pc_cnt == pb; i++) begin
            @(negedge clk); #1;
            if (busy !== 1'b1) begin busy_ok = 1'b0; busy_bad = 32'(i); end
        end
        dec_valid = 1'b0;
        check(busy_ok, "R9 busy through sequence", busy_bad, 32'hFFFF_FFFF);
        @(negedge clk); #1;
        check(busy === 1'b0, "R9 busy falls after pc_load", {31'd0, busy}, 32'h0);
        check(pc_cnt == pb + 1, "R9 single pc_load", 32'(pc_cnt - pb), 32'd1);
        check(spwe_cnt == spb + 1, "R8 single sp_we", 32'(spwe_cnt - spb), 32'd1);
        check(wr_cnt == wb + 4, "R4 four writes", 32'(wr_cnt - wb), 32'd4);
        exp_w[0] = 16'h0020; exp_w[1] = pc[15:0];
        exp_w[2] = pc[31:16]; exp_w[3] = sr;
        for (int k = 0; k < 4; k++) begin
            check(wa_log[(wb + k) % 64] == sp - 32'(2 * (k + 1)), "R4 write address",
                  wa_log[(wb + k) % 64], sp - 32'(2 * (k + 1)));
            check(wd_log[(wb + k) % 64] == exp_w[k], "R5 frame word",
                  {16'd0, wd_log[(wb + k) % 64]}, {16'd0, exp_w[k]});
        end
        check(ra_log == vbr + 32'h20, "R7 vector address", ra_log, vbr + 32'h20);
        check(pcn_log == vec_mem(vbr + 32'h20), "R8 new pc", pcn_log, vec_mem(vbr + 32'h20));
        check(spo_log == sp - 32'd8, "R8 final sp", spo_log, sp - 32'd8);
    endtask

    task automatic no_start(input bit priv, input logic [15:0] sr, input string tag);
        int wb = wr_cnt;
        bit ok = 1'b1;
        @(negedge clk);
        dec_valid = 1'b1; dec_priv = priv; sr_in = sr;
        cur_pc = 32'h0000_3000; sp_in = 32'h0000_9000;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (exec_inhibit || busy || mem_wr_req || vec_rd_req) ok = 1'b0;
            @(negedge clk);
        end
        dec_valid = 1'b0;
        check(ok && wr_cnt == wb, tag, {31'd0, ok}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !exec_inhibit && !mem_wr_req && !vec_rd_req && !pc_load
              && !sr_we && !sp_we, "R10 reset state",
              {25'd0, busy, exec_inhibit, mem_wr_req, vec_rd_req, pc_load, sr_we, sp_we},
              32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run_exc(32'h0000_1000, 16'h0000, 32'h0000_8000, 32'h0000_0000, 1'b0);
        run_exc(32'h00FF_EE02, 16'hC71F, 32'h0001_0000, 32'h0000_4000, 1'b0); // trace bits set
        run_exc(32'h1234_5678, 16'h8004, 32'h0000_0004, 32'hFFFF_FF00, 1'b0); // sp wraps
        run_exc(32'hABCD_0010, 16'h4700, 32'h0000_2000, 32'h0000_1000, 1'b1); // R9 poke
        no_start(1'b1, 16'h2700, "R2 supervisor mode ignored");
        no_start(1'b0, 16'h0000, "R2 non-privileged ignored");
        no_start(1'b0, 16'h2000, "R2 non-privileged supervisor ignored");

        for (int t = 0; t < 20; t++) begin
            logic [31:0] rpc = $urandom() & 32'hFFFF_FFFE;
            logic [15:0] rsr = 16'($urandom()) & 16'hDFFF;
            logic [31:0] rsp = $urandom() & 32'hFFFF_FFFE;
            logic [31:0] rvb = $urandom() & 32'hFFFF_FC00;
            run_exc(rpc, rsr, rsp, rvb, 1'(t % 3 == 0));
            if (t % 5 == 0) no_start(1'b1, 16'($urandom()) | 16'h2000, "R2 random supervisor");
        end

        finish_run();
    end

endmodule